// File: doc/BRIEF.md
# CPU-Space Special Cycle Sequencer

This block is the bus master for two special bus cycles that a processor core issues in the CPU address space. It does not carry data to or from memory. It encodes the kind of cycle in the address lines while the function code marks the access as CPU space. The core raises one of two request levels:

- a breakpoint request, which makes the block run an acknowledge read on the strobe-based bus and then report the result back to the core;
- a stop request with the current three-bit interrupt mask, which makes the block run a broadcast write carrying that mask and then hand the mask to the clock-control logic.

The external responder answers the acknowledge read with a transfer acknowledge (DSACK) or a bus error (BERR). Both arrive asynchronously and pass through a two-flop synchronizer. The broadcast write does not wait for the responder; it ends itself on fast-termination timing. When the core does not own the bus, the broadcast is kept off the pins, but the mask hand-off still takes place. The core holds a request until the matching completion pulse appears.

Top module: `cpuspace_seq`

## Requirements
- R1: After reset, the strobes and the drive enable are low, and address, function code and data are all zero.
- R2: A breakpoint acknowledge drives address 0x0001E (bits [19:16] zero, bits [4:1] one), function code 3'b111, read (rw_o high) and word size.
- R3: In each cycle the address, the function code and drive_en_o are valid for one clock with the strobes low, before the strobes rise.
- R4: as_o and ds_o rise and fall together. On an acknowledge read they stay high until the synchronized DSACK or BERR is seen, and then they drop.
- R5: bkpt_done_o pulses for one clock only after the strobes have dropped and both DSACK and BERR have returned low. bkpt_berr_o is high with it exactly when BERR ended the cycle.
- R6: A shown broadcast drives address 0x3FFFE, function code 3'b111, write (rw_o low), word size, the mask on data bits [10:8] and zero on every other data bit.
- R7: A broadcast holds the strobes high for exactly one clock and needs no external response. BERR during it has no effect on its timing or its result.
- R8: When bus_owned_i is low at acceptance, the broadcast drives no strobe and no drive enable, and mask_load_o still pulses.
- R9: When both requests are pending in the same cycle, the breakpoint acknowledge runs first and the broadcast follows.
- R10: mask_load_o pulses for one clock at the end of each broadcast, with mask_val_o equal to the mask sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkpt_req_i | input | 1 | Breakpoint acknowledge request, held until done |
| stop_req_i | input | 1 | Stop broadcast request, held until mask_load_o |
| stop_mask_i | input | 3 | Interrupt mask to broadcast |
| bus_owned_i | input | 1 | Core currently owns the external bus |
| dsack_i | input | 1 | Asynchronous transfer acknowledge, active high |
| berr_i | input | 1 | Asynchronous bus error, active high |
| addr_o | output | 20 | Address bus |
| fc_o | output | 3 | Function code |
| rw_o | output | 1 | 1 = read, 0 = write |
| size_word_o | output | 1 | Word-size transfer |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| data_o | output | 16 | Write data |
| drive_en_o | output | 1 | Bus outputs are being driven |
| bkpt_done_o | output | 1 | Start hardware breakpoint processing (pulse) |
| bkpt_berr_o | output | 1 | The acknowledge read ended in bus error |
| mask_load_o | output | 1 | Mask hand-off to clock control (pulse) |
| mask_val_o | output | 3 | Mask being handed off |

## Verification
The two functions that can fall in the same cycle are the breakpoint request and the stop request. The bench raises both on one edge, with random masks and random bus ownership. It then checks that the acknowledge read appears first with its own address and that the broadcast follows with the right mask. A second overlap is BERR arriving during a broadcast. The bench raises it while the broadcast strobe is high and checks that the strobe length, the mask hand-off and the absence of any error report are unchanged.

// File: rtl/cpuspace_pkg.sv
package cpuspace_pkg;
  localparam int ADDR_W  = 20;
  localparam int DATA_W  = 16;
  localparam int MASK_W  = 3;
  localparam int MASK_LSB = 8;
  localparam int FC_W    = 3;
  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
  localparam logic [ADDR_W-1:0] ADDR_BKPT_ACK = 20'h0001E;
  localparam logic [ADDR_W-1:0] ADDR_STOP_BC  = 20'h3FFFE;
  localparam int NSTATE  = 6;
  localparam int ST_IDLE = 0;
  localparam int ST_SETUP = 1;
  localparam int ST_STROBE = 2;
  localparam int ST_WAIT = 3;
  localparam int ST_REL  = 4;
  localparam int ST_DONE = 5;
endpackage

// File: rtl/cpuspace_sync.sv
module cpuspace_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/cpuspace_ctrl.sv
module cpuspace_ctrl
  import cpuspace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkpt_req_i,
  input  logic              stop_req_i,
  input  logic [MASK_W-1:0] stop_mask_i,
  input  logic              bus_owned_i,
  input  logic              ack_s_i,
  input  logic              err_s_i,
  output logic              drive_o,
  output logic              strobe_o,
  output logic              is_stop_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              bkpt_done_o,
  output logic              bkpt_berr_o,
  output logic              mask_load_o
);
  logic [NSTATE-1:0] st_q, st_d;
  logic kind_stop_q, kind_stop_d, shown_q, shown_d, err_q;
  logic [MASK_W-1:0] mask_q;
  logic accept_en, err_en, term_any;

  assign term_any  = ack_s_i | err_s_i;
  assign accept_en = st_q[ST_IDLE] & (bkpt_req_i | stop_req_i);
  assign err_en    = st_q[ST_WAIT] & term_any;

  always_comb begin
    st_d        = '0;
    kind_stop_d = ~bkpt_req_i;
    shown_d     = bkpt_req_i | bus_owned_i;
    if (st_q[ST_IDLE]) begin
      if (bkpt_req_i | stop_req_i) st_d[ST_SETUP] = 1'b1;
      else                         st_d[ST_IDLE]  = 1'b1;
    end else if (st_q[ST_SETUP]) begin
      st_d[ST_STROBE] = 1'b1;
    end else if (st_q[ST_STROBE]) begin
      if (kind_stop_q) st_d[ST_REL]  = 1'b1;
      else             st_d[ST_WAIT] = 1'b1;
    end else if (st_q[ST_WAIT]) begin
      if (term_any) st_d[ST_REL]  = 1'b1;
      else          st_d[ST_WAIT] = 1'b1;
    end else if (st_q[ST_REL]) begin
      if (kind_stop_q || !term_any) st_d[ST_DONE] = 1'b1;
      else                          st_d[ST_REL]  = 1'b1;
    end else begin
      st_d[ST_IDLE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= NSTATE'(1) << ST_IDLE;
      kind_stop_q <= 1'b0;
      shown_q     <= 1'b0;
      mask_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_en) begin
        kind_stop_q <= kind_stop_d;
        shown_q     <= shown_d;
        mask_q      <= stop_mask_i;
        err_q       <= 1'b0;
      end
      if (err_en) err_q <= err_s_i;
    end
  end

  assign drive_o     = shown_q & (st_q[ST_SETUP] | st_q[ST_STROBE] | st_q[ST_WAIT]);
  assign strobe_o    = shown_q & (st_q[ST_STROBE] | st_q[ST_WAIT]);
  assign is_stop_o   = kind_stop_q;
  assign mask_o      = mask_q;
  assign bkpt_done_o = st_q[ST_DONE] & ~kind_stop_q;
  assign bkpt_berr_o = st_q[ST_DONE] & ~kind_stop_q & err_q;
  assign mask_load_o = st_q[ST_DONE] & kind_stop_q;

  assert_state_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);
  assert_hold_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_WAIT] && !term_any) |=> strobe_o);
  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(drive_o) && $past(!strobe_o));
  assert_release_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_REL] && !kind_stop_q && term_any) |=> !bkpt_done_o);
  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_done_o |-> !strobe_o && $past(!strobe_o));
  assert_stop_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && kind_stop_q) |=> !strobe_o);
  assert_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shown_q |-> (!strobe_o && !drive_o));
  assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_load_o && bkpt_done_o));
endmodule

// File: rtl/cpuspace_bus_enc.sv
module cpuspace_bus_enc
  import cpuspace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_i,
  input  logic              strobe_i,
  input  logic              is_stop_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic              rw_o,
  output logic              size_word_o,
  output logic              as_o,
  output logic              ds_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int MASK_MSB = MASK_LSB + MASK_W - 1;

  always_comb begin
    addr_o      = '0;
    fc_o        = '0;
    rw_o        = 1'b1;
    size_word_o = 1'b0;
    data_o      = '0;
    if (drive_i) begin
      fc_o        = FC_CPU_SPACE;
      size_word_o = 1'b1;
      if (is_stop_i) begin
        addr_o                   = ADDR_STOP_BC;
        rw_o                     = 1'b0;
        data_o[MASK_MSB:MASK_LSB] = mask_i;
      end else begin
        addr_o = ADDR_BKPT_ACK;
      end
    end
  end

  assign as_o = strobe_i;
  assign ds_o = strobe_i;

  assert_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |-> (addr_o == '0 && fc_o == '0 && data_o == '0));
  assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    as_o == ds_o);
endmodule

// File: rtl/cpuspace_seq.sv
module cpuspace_seq
  import cpuspace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkpt_req_i,
  input  logic              stop_req_i,
  input  logic [MASK_W-1:0] stop_mask_i,
  input  logic              bus_owned_i,
  input  logic              dsack_i,
  input  logic              berr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o,
  output logic              rw_o,
  output logic              size_word_o,
  output logic              as_o,
  output logic              ds_o,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_en_o,
  output logic              bkpt_done_o,
  output logic              bkpt_berr_o,
  output logic              mask_load_o,
  output logic [MASK_W-1:0] mask_val_o
);
  logic [1:0] rst_pipe_q;
  logic rst_int_n;
  logic [1:0] term_s;
  logic drive, strobe, is_stop;
  logic [MASK_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  cpuspace_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .async_i({berr_i, dsack_i}), .sync_o(term_s)
  );

  cpuspace_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .bkpt_req_i(bkpt_req_i), .stop_req_i(stop_req_i),
    .stop_mask_i(stop_mask_i), .bus_owned_i(bus_owned_i),
    .ack_s_i(term_s[0]), .err_s_i(term_s[1]),
    .drive_o(drive), .strobe_o(strobe), .is_stop_o(is_stop), .mask_o(mask),
    .bkpt_done_o(bkpt_done_o), .bkpt_berr_o(bkpt_berr_o),
    .mask_load_o(mask_load_o)
  );

  cpuspace_bus_enc u_enc (
    .clk(clk), .rst_n(rst_int_n),
    .drive_i(drive), .strobe_i(strobe), .is_stop_i(is_stop), .mask_i(mask),
    .addr_o(addr_o), .fc_o(fc_o), .rw_o(rw_o), .size_word_o(size_word_o),
    .as_o(as_o), .ds_o(ds_o), .data_o(data_o)
  );

  assign drive_en_o = drive;
  assign mask_val_o = mask;
endmodule

// File: tb/cpuspace_seq_tb.sv
module cpuspace_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bkpt_req = 1'b0, stop_req = 1'b0, bus_owned = 1'b1, dsack = 1'b0, berr = 1'b0;
  logic [2:0] mask = '0;
  logic [19:0] addr; logic [2:0] fc; logic rw, sz, as_s, ds_s, drv;
  logic [15:0] data; logic bdone, bberr, mload; logic [2:0] mval;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cpuspace_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bkpt_req_i(bkpt_req), .stop_req_i(stop_req),
    .stop_mask_i(mask), .bus_owned_i(bus_owned), .dsack_i(dsack), .berr_i(berr),
    .addr_o(addr), .fc_o(fc), .rw_o(rw), .size_word_o(sz), .as_o(as_s), .ds_o(ds_s),
    .data_o(data), .drive_en_o(drv), .bkpt_done_o(bdone), .bkpt_berr_o(bberr),
    .mask_load_o(mload), .mask_val_o(mval)
  );

  function automatic logic [15:0] exp_data(input logic [2:0] m);
    return {5'b0, m, 8'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic run_bkpt(input bit use_err, input int dly);
    int t = 0;
    while (!drv && t < 20) begin step(); t++; end
    chk(drv, "R2 drive", 32'(drv), 1);
    chk(addr == 20'h0001E && fc == 3'b111 && rw && sz, "R2 bkpt fields", {addr, fc, rw, sz}, {20'h0001E, 3'b111, 2'b11});
    chk(!as_s && !ds_s, "R3 setup strobes low", 32'(as_s), 0);
    step();
    chk(as_s && ds_s, "R4 strobes high", {as_s, ds_s}, 2'b11);
    for (int i = 0; i < dly; i++) step();
    chk(as_s, "R4 held without response", 32'(as_s), 1);
    if (use_err) berr = 1'b1; else dsack = 1'b1;
    t = 0;
    while (as_s && t < 8) begin step(); t++; end
    chk(!as_s && !ds_s, "R4 strobes dropped", {as_s, ds_s}, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!bdone, "R5 no done while response held", 32'(bdone), 0);
    end
    dsack = 1'b0; berr = 1'b0;
    t = 0;
    while (!bdone && t < 8) begin step(); t++; end
    chk(bdone, "R5 done pulse", 32'(bdone), 1);
    chk(bberr == use_err, "R5 berr report", 32'(bberr), 32'(use_err));
    bkpt_req = 1'b0;
    step();
    chk(!bdone, "R5 done single pulse", 32'(bdone), 0);
  endtask

  task automatic run_stop(input logic [2:0] m, input bit shown, input bit inject_err);
    int t = 0;
    bit saw_strobe = 0;
    while (!drv && !mload && t < 20) begin
      if (as_s) saw_strobe = 1;
      step(); t++;
    end
    if (shown) begin
      chk(drv, "R6 drive", 32'(drv), 1);
      chk(addr == 20'h3FFFE && fc == 3'b111 && !rw && sz, "R6 stop fields", {addr, fc, rw, sz}, {20'h3FFFE, 3'b111, 2'b01});
      chk(data == exp_data(m), "R6 mask on data", 32'(data), 32'(exp_data(m)));
      chk(!as_s, "R3 setup strobes low", 32'(as_s), 0);
      step();
      chk(as_s && ds_s, "R7 strobe high", {as_s, ds_s}, 2'b11);
      if (inject_err) berr = 1'b1;
      step();
      chk(!as_s, "R7 one-clock strobe", 32'(as_s), 0);
      t = 0;
      while (!mload && t < 6) begin step(); t++; end
    end else begin
      t = 0;
      while (!mload && t < 10) begin
        if (as_s || drv) saw_strobe = 1;
        step(); t++;
      end
      chk(!saw_strobe, "R8 hidden cycle", 32'(saw_strobe), 0);
    end
    chk(mload, "R10 mask load", 32'(mload), 1);
    chk(mval == m, "R10 mask value", 32'(mval), 32'(m));
    chk(!bberr && !bdone, "R7 berr ignored", {bberr, bdone}, 0);
    stop_req = 1'b0;
    berr = 1'b0;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) step();
    chk(!as_s && !ds_s && !drv && addr == 0 && fc == 0 && data == 0, "R1 reset state", {as_s, ds_s, drv}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(!as_s && !drv && !bdone && !mload, "R1 idle after reset", {as_s, drv, bdone, mload}, 0);

    bkpt_req = 1'b1; run_bkpt(1'b0, 2);
    bkpt_req = 1'b1; run_bkpt(1'b1, 0);
    mask = 3'd5; bus_owned = 1'b1; stop_req = 1'b1; run_stop(3'd5, 1'b1, 1'b1);
    mask = 3'd7; bus_owned = 1'b0; stop_req = 1'b1; run_stop(3'd7, 1'b0, 1'b0);
    mask = 3'd2; bus_owned = 1'b1; bkpt_req = 1'b1; stop_req = 1'b1;
    step();
    chk(drv && addr == 20'h0001E, "R9 breakpoint first", addr, 20'h0001E);
    run_bkpt(1'b0, 1);
    run_stop(3'd2, 1'b1, 1'b0);

    for (int it = 0; it < 40; it++) begin
      int op;
      logic [2:0] m;
      bit own, e;
      int d;
      op = int'($urandom % 3);
      m = 3'($urandom);
      own = 1'($urandom);
      e = 1'($urandom);
      d = int'($urandom % 5);
      mask = m; bus_owned = own;
      if (op == 0) begin bkpt_req = 1'b1; run_bkpt(e, d); end
      else if (op == 1) begin stop_req = 1'b1; run_stop(m, own, e); end
      else begin
        bkpt_req = 1'b1; stop_req = 1'b1;
        run_bkpt(e, d);
        run_stop(m, own, ~e);
      end
      repeat (int'($urandom % 3)) step();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule